// File: doc/BRIEF.md
# Programmable Crossbar Switch

This block connects a set of input lines to a set of output lines through a grid of crosspoints. Each crosspoint holds one configuration bit. An output line carries the logical OR of every input that its column has enabled. Any input can therefore reach any output, and one input can feed several outputs at the same time. The data path from inputs to outputs is purely combinational. Only the configuration is clocked.

Programming reuses the data inputs. The caller places a pattern on the input lines and raises the write strobe of one or more output columns. On the next rising clock edge, each strobed column takes the whole pattern as its new contents. A column strobed with a single input high therefore holds exactly one connection.

A synchronous reset empties the whole grid and holds every output low. A preset strobe loads a complete built-in mapping in one cycle. The selectable mappings are fan-out from input 0, mirrored (corner turn), straight-through, and empty.

Top module: `xbar_switch`

## Requirements
- R1: Each output `dout[j]` equals the OR, over every input `i`, of `din[i]` AND crosspoint bit (i, j). A column with several bits set passes any of those inputs.
- R2: When `col_we[j]` is high at a rising edge, column j takes the value of `din` as its new contents, replacing what it held before.
- R3: When several `col_we` bits are high in the same cycle, every strobed column takes the same `din` pattern. This builds a fan-out mapping in one write.
- R4: A column whose strobe is low at an edge keeps its contents.
- R5: A column with no bit set drives its output at 0 for every input pattern.
- R6: While `rst` is high, every output is 0. After a rising edge with `rst` high, every crosspoint bit is 0, so the outputs stay at 0 until the grid is programmed again.
- R7: `preset_load` with `preset_sel` = 0 connects input 0 to every output and nothing else.
- R8: `preset_load` with `preset_sel` = 1 connects input N_IN-1-j to output j for each j below N_IN. Any other column is left empty.
- R9: `preset_load` with `preset_sel` = 2 connects input j to output j for each j below N_IN. Any other column is left empty.
- R10: `preset_load` with `preset_sel` = 3 empties every column.
- R11: In a single cycle, `rst` overrides `preset_load`, and `preset_load` overrides every `col_we` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration bits |
| rst | input | 1 | Synchronous active-high reset; also forces the outputs low |
| din | input | N_IN | Switched data, and the write pattern during programming |
| col_we | input | N_OUT | Per-output-column write strobes |
| preset_load | input | 1 | Loads the mapping chosen by preset_sel |
| preset_sel | input | 2 | 0 fan-out, 1 mirrored, 2 straight, 3 empty |
| dout | output | N_OUT | Switched outputs |

## Verification
The clocked properties take for granted that `din`, `col_we`, `preset_load` and `preset_sel` hold known values at each rising edge. They also assume `rst` is high at the first edge, so the grid starts from a defined state. The stimulus keeps to this by driving every input on the falling edge from fully initialised variables, and by starting in reset. Random mappings place exactly one input in each column, which keeps them legal. Directed writes add columns with several bits set, and same-cycle collisions of reset, preset and write strobes.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [1:0] {
        PRE_FANOUT   = 2'd0,
        PRE_MIRROR   = 2'd1,
        PRE_STRAIGHT = 2'd2,
        PRE_EMPTY    = 2'd3
    } preset_e;

    localparam int NO_SRC = -1;

    // Source input that a preset routes to output column col, or NO_SRC.
    function automatic int preset_src(preset_e sel, int col, int n_in);
        case (sel)
            PRE_FANOUT:   return 0;
            PRE_MIRROR:   return (col < n_in) ? (n_in - 1 - col) : NO_SRC;
            PRE_STRAIGHT: return (col < n_in) ? col : NO_SRC;
            default:      return NO_SRC;
        endcase
    endfunction

endpackage

// File: rtl/xbar_preset_gen.sv
module xbar_preset_gen
    import xbar_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input  preset_e                       sel,
    output logic [N_OUT-1:0][N_IN-1:0]    cols
);

    always_comb begin
        for (int j = 0; j < N_OUT; j++) begin
            for (int i = 0; i < N_IN; i++) begin
                cols[j][i] = (preset_src(sel, j, N_IN) == i);
            end
        end
    end

endmodule

// File: rtl/xbar_cfg_store.sv
module xbar_cfg_store #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_IN-1:0]               din,
    input  logic [N_OUT-1:0]              col_we,
    input  logic                          preset_load,
    input  logic [N_OUT-1:0][N_IN-1:0]    preset_cols,
    output logic [N_OUT-1:0][N_IN-1:0]    cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (preset_load) begin
            cfg <= preset_cols;
        end else begin
            for (int j = 0; j < N_OUT; j++) begin
                if (col_we[j]) cfg[j] <= din;
            end
        end
    end

    // R6 / R11: reset empties the grid whatever else is requested
    p_reset_clears_r6: assert property (@(posedge clk) rst |=> cfg == '0);

    // R11: a preset beats any column strobe in the same cycle
    p_preset_wins_r11: assert property (@(posedge clk) disable iff (rst)
        preset_load |=> cfg == $past(preset_cols));

    for (genvar j = 0; j < N_OUT; j++) begin : g_col_chk
        // R2: a strobed column takes the input pattern
        p_col_load_r2: assert property (@(posedge clk) disable iff (rst)
            (!preset_load && col_we[j]) |=> cfg[j] == $past(din));
        // R4: an unstrobed column is left alone
        p_col_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (!preset_load && !col_we[j]) |=> $stable(cfg[j]));
    end

endmodule

// File: rtl/xbar_or_column.sv
module xbar_or_column #(
    parameter int N_IN = 8
) (
    input  logic [N_IN-1:0] din,
    input  logic [N_IN-1:0] sel,
    input  logic            rst,
    output logic            dout
);

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            acc = acc | (din[i] & sel[i]);
        end
        dout = acc & ~rst;
    end

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
    import xbar_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   din,
    input  logic [N_OUT-1:0]  col_we,
    input  logic              preset_load,
    input  logic [1:0]        preset_sel,
    output logic [N_OUT-1:0]  dout
);

    logic [N_OUT-1:0][N_IN-1:0] preset_cols;
    logic [N_OUT-1:0][N_IN-1:0] cfg;

    xbar_preset_gen #(.N_IN(N_IN), .N_OUT(N_OUT)) u_preset (
        .sel  (preset_e'(preset_sel)),
        .cols (preset_cols)
    );

    xbar_cfg_store #(.N_IN(N_IN), .N_OUT(N_OUT)) u_store (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .col_we      (col_we),
        .preset_load (preset_load),
        .preset_cols (preset_cols),
        .cfg         (cfg)
    );

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        xbar_or_column #(.N_IN(N_IN)) u_col (
            .din  (din),
            .sel  (cfg[j]),
            .rst  (rst),
            .dout (dout[j])
        );

        // R5: an empty column never drives high
        p_empty_col_low_r5: assert property (@(posedge clk) disable iff (rst)
            (cfg[j] == '0) |-> !dout[j]);
    end

    // R6: outputs are held low during reset
    p_reset_out_low_r6: assert property (@(posedge clk) rst |-> dout == '0);

endmodule

// File: tb/xbar_switch_test.sv
module xbar_switch_test;

    localparam int NI = 8;
    localparam int NO = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] din = '0;
    logic [NO-1:0] col_we = '0;
    logic          preset_load = 1'b0;
    logic [1:0]    preset_sel = 2'd0;
    logic [NO-1:0] dout;

    always #2 clk = ~clk;

    xbar_switch #(.N_IN(NI), .N_OUT(NO)) uut (
        .clk(clk), .rst(rst), .din(din), .col_we(col_we),
        .preset_load(preset_load), .preset_sel(preset_sel), .dout(dout)
    );

    logic [NI-1:0] ref_map [NO];
    int errs = 0;
    int checks = 0;
    bit done = 0;

    function automatic logic [NO-1:0] model(logic [NI-1:0] v);
        logic [NO-1:0] r;
        for (int j = 0; j < NO; j++) r[j] = |(v & ref_map[j]);
        return r;
    endfunction

    task automatic check(input logic [NO-1:0] got, input logic [NO-1:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: dout=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [NI-1:0] v, input string tag);
        @(negedge clk);
        din = v;
        #1;
        check(dout, model(v), tag);
    endtask

    task automatic verify_map(input string tag);
        for (int k = 0; k < NI; k++) apply(NI'(1) << k, tag);
        apply('1, tag);
        apply('0, tag);
    endtask

    task automatic strobe(input logic [NO-1:0] mask, input logic [NI-1:0] data);
        @(negedge clk);
        din = data;
        col_we = mask;
        @(posedge clk);
        for (int j = 0; j < NO; j++) if (mask[j]) ref_map[j] = data;
        @(negedge clk);
        col_we = '0;
    endtask

    task automatic set_ref_preset(input logic [1:0] sel);
        for (int j = 0; j < NO; j++) begin
            case (sel)
                2'd0: ref_map[j] = NI'(1);
                2'd1: ref_map[j] = (j < NI) ? (NI'(1) << (NI - 1 - j)) : '0;
                2'd2: ref_map[j] = (j < NI) ? (NI'(1) << j) : '0;
                default: ref_map[j] = '0;
            endcase
        end
    endtask

    task automatic do_preset(input logic [1:0] sel);
        @(negedge clk);
        preset_sel = sel;
        preset_load = 1'b1;
        @(negedge clk);
        preset_load = 1'b0;
        set_ref_preset(sel);
    endtask

    task automatic clear_ref();
        for (int j = 0; j < NO; j++) ref_map[j] = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: dout=%b expected=completion", dout);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_ref();
        // R6: outputs low while reset is held
        @(negedge clk);
        din = '1;
        #1;
        check(dout, '0, "R6 during reset");
        repeat (2) @(negedge clk);
        rst = 1'b0;
        verify_map("R6 empty after reset");
        verify_map("R5 empty columns");

        // R1 / R2 / R4: random legal mappings, one column at a time
        for (int m = 0; m < 4; m++) begin
            for (int j = 0; j < NO; j++) begin
                int k;
                k = $urandom_range(NI - 1, 0);
                strobe(NO'(1) << j, NI'(1) << k);
            end
            verify_map("R2 column write");
            for (int t = 0; t < 20; t++) apply(NI'($urandom), "R1 random data");
        end

        // R2: overwrite, with several bits in one column (R1 OR behaviour)
        strobe(NO'(1) << 3, 8'b1001_0010);
        verify_map("R1 multi-bit column");
        strobe(NO'(1) << 3, 8'b0000_0100);
        verify_map("R2 overwrite");

        // R4: one column written, others kept
        strobe(NO'(1) << 6, 8'b0100_0000);
        verify_map("R4 others unchanged");

        // R3: several columns strobed together
        strobe(8'b1010_0101, 8'b0001_0000);
        verify_map("R3 shared write");
        for (int t = 0; t < 10; t++) apply(NI'($urandom), "R3 shared data");

        // R7..R10: presets
        do_preset(2'd0);
        verify_map("R7 fan-out preset");
        do_preset(2'd1);
        verify_map("R8 mirror preset");
        for (int t = 0; t < 10; t++) apply(NI'($urandom), "R8 mirror data");
        do_preset(2'd2);
        verify_map("R9 straight preset");
        do_preset(2'd3);
        verify_map("R10 empty preset");
        for (int t = 0; t < 5; t++) apply(NI'($urandom), "R5 empty data");

        // R11: preset beats column writes
        @(negedge clk);
        din = '1;
        col_we = '1;
        preset_sel = 2'd1;
        preset_load = 1'b1;
        @(negedge clk);
        preset_load = 1'b0;
        col_we = '0;
        set_ref_preset(2'd1);
        verify_map("R11 preset over write");

        // R11 / R6: reset beats preset and writes
        @(negedge clk);
        rst = 1'b1;
        din = '1;
        col_we = '1;
        preset_sel = 2'd0;
        preset_load = 1'b1;
        #1;
        check(dout, '0, "R6 outputs low in reset");
        @(negedge clk);
        rst = 1'b0;
        preset_load = 1'b0;
        col_we = '0;
        clear_ref();
        verify_map("R11 reset over preset");
        for (int t = 0; t < 10; t++) apply(NI'($urandom), "R6 stays low");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule